// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a clock generator. It listens on a two-wire serial bus at standard-mode speed (100 kbit/s) and holds seven 8-bit configuration bytes. Those bytes are brought out in parallel so that the output-control logic can use them directly. A 100 MHz-class system clock oversamples the bus lines. Each line goes through a two-stage synchronizer and a glitch filter. Start, stop and bit edges are then detected on the clean signals.

The block has no register pointer. A write addresses the slave, sends two filler bytes (nominally a command code and a byte count), and then streams data. The first data byte lands in byte 0, the next in byte 1, and so on until the controller issues a stop. A read also always begins at byte 0 and streams upward for as long as the controller acknowledges.

The SDA output is an active-high pull-down request for an open-drain pad; the pad itself sits outside the block.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte D2h (7-bit address 69h, R/W bit 0 = write) and D3h (R/W bit 1 = read). Any other address byte is not acknowledged, and later bytes are also not acknowledged until a new start condition.
- R2: In a write, the two bytes that follow the address are acknowledged, and their values change no configuration byte.
- R3: Write data bytes after the two filler bytes are stored into byte 0, 1, 2, ... in ascending order, and each one is acknowledged.
- R4: A stop after any complete byte ends the write, and configuration bytes not reached keep their previous values.
- R5: Write data bytes beyond byte 6 are acknowledged and change nothing.
- R6: A read returns byte 0 first and then successive bytes, for as long as the controller acknowledges (SDA low). Positions past byte 6 return FFh. A controller not-acknowledge ends the data phase, and the next read starts again at byte 0.
- R7: After reset, byte 0 is 00h and bytes 1 to 6 are FFh.
- R8: The slave's SDA pull-down changes only while the filtered SCL is low.
- R9: A pulse on SCL or SDA lasting fewer than FILT_LEN system clocks is ignored, so it creates no bit, start or stop.
- R10: Configuration byte i appears on cfg_bytes[8*i+7 : 8*i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release it |
| cfg_bytes | output | 56 | All configuration bytes, byte i at bits 8*i+7:8*i |

## Verification
Assertions check three things on every cycle:
- the SDA pull-down never changes while the filtered SCL is high;
- the filtered lines only take values the synchronizer held just before;
- the configuration bytes stay constant unless a write strobe targets a valid index, and the slave never pulls SDA while idle.

Only the bench scenarios can show the following:
- the ordering of bytes;
- that the filler bytes are discarded;
- the refusal of foreign addresses;
- the behaviour of reads past the last byte;
- immunity to short glitches.

To show these, the bench sweeps write lengths from zero to beyond the register count and compares the results against a model of the bytes.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  localparam int FILLER_BYTES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_t;

  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return rx[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_f
);
  localparam int CNTW = $clog2(FILT_LEN + 1);

  logic       sync1, sync2;
  logic [CNTW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_f  <= 1'b1;
      run_cnt <= '0;
    end else if (sync2 != line_f) begin
      if (run_cnt == CNTW'(FILT_LEN - 1)) begin
        line_f  <= sync2;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

  AST_FILTER_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_f) |-> line_f == $past(sync2)); // R9

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;

endmodule

// File: rtl/cfg_byte_engine.sv
module cfg_byte_engine
  import cfgi2c_pkg::*;
#(
  parameter int         NREG     = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IW       = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int        PW       = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_ptr,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_drive
);
  localparam int CMAX = FILLER_BYTES + NREG;
  localparam int CW   = $clog2(CMAX + 1);

  bus_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sh;
  logic [7:0]    tx_sh;
  logic          is_addr;
  logic          rd_mode;
  logic          ack_drv;
  logic          m_ack;
  logic [CW-1:0] data_cnt;

  function automatic logic in_window(input logic [CW-1:0] cnt);
    return (cnt >= CW'(FILLER_BYTES)) && (cnt < CW'(CMAX));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= 8'hFF;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      ack_drv  <= 1'b0;
      m_ack    <= 1'b0;
      data_cnt <= '0;
      rd_ptr   <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        state    <= ST_RX;
        is_addr  <= 1'b1;
        bit_cnt  <= '0;
        ack_drv  <= 1'b0;
        data_cnt <= '0;
        rd_ptr   <= '0;
      end else if (ev_stop) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (is_addr) begin
                if (addr_hit(rx_sh, DEV_ADDR)) begin
                  ack_drv <= 1'b1;
                  rd_mode <= rx_sh[0];
                  state   <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                ack_drv <= 1'b1;
                state   <= ST_RX_ACK;
                if (in_window(data_cnt)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IW'(data_cnt - CW'(FILLER_BYTES));
                  wr_data <= rx_sh;
                end
                if (data_cnt != CW'(CMAX)) data_cnt <= data_cnt + 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              is_addr <= 1'b0;
              if (is_addr && rd_mode) begin
                state <= ST_TX;
                tx_sh <= rd_data;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                state   <= ST_TX_ACK;
                bit_cnt <= '0;
                tx_sh   <= 8'hFF;
                if (rd_ptr != PW'(NREG)) rd_ptr <= rd_ptr + 1'b1;
              end else begin
                tx_sh   <= {tx_sh[6:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (m_ack) begin
                state <= ST_TX;
                tx_sh <= rd_data;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive = (state == ST_TX) ? ~tx_sh[7] : ack_drv;

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive) |-> !scl_f); // R8
  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_drive); // R1
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == ST_RX) && (bit_cnt == 4'd0)); // R1

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfgi2c_pkg::*;
#(
  parameter int  NREG = 7,
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int PW   = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PW-1:0]     rd_ptr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] regs [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[gi] <= reg_reset_value(gi);
      else if (wr_en && wr_idx == IW'(gi)) regs[gi] <= wr_data;
    end
    assign regs_flat[gi*8 +: 8] = regs[gi];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++) begin
      if (rd_ptr == PW'(i)) rd_data = regs[i];
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat)); // R4
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_idx) < NREG); // R5

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NREG     = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NREG*8-1:0] cfg_bytes
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PW = $clog2(NREG + 1);

  logic [1:0]    raw_lines;
  logic [1:0]    clean_lines;
  logic          ev_start, ev_stop, scl_rise, scl_fall;
  logic [7:0]    rd_data;
  logic [PW-1:0] rd_ptr;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  assign raw_lines = {sda_in, scl_in};

  for (genvar gl = 0; gl < 2; gl++) begin : g_line
    i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(raw_lines[gl]),
      .line_f (clean_lines[gl])
    );
  end

  i2c_bus_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (clean_lines[0]),
    .sda_f   (clean_lines[1]),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  cfg_byte_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (clean_lines[0]),
    .sda_f    (clean_lines[1]),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .rd_data  (rd_data),
    .rd_ptr   (rd_ptr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_drive(sda_pull)
  );

  cfg_reg_file #(.NREG(NREG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_ptr   (rd_ptr),
    .rd_data  (rd_data),
    .regs_flat(cfg_bytes)
  );

endmodule

// File: tb/sim_cfg_i2c_slave.sv
`timescale 1ns/1ps
module sim_cfg_i2c_slave;
  localparam int NREG = 7;
  localparam int Q    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] cfg_bytes;
  logic sda_bus;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  cfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .cfg_bytes(cfg_bytes)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_cfg(input string req);
    logic [NREG*8-1:0] e;
    for (int i = 0; i < NREG; i++) e[i*8 +: 8] = model[i];
    chk(req, 64'(cfg_bytes), 64'(e));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q/2);
      if (glitch) begin
        scl_m = 1'b0; wq(2); scl_m = 1'b1; wq(2);
        sda_m = ~b[i]; wq(2); sda_m = b[i];
        wq(Q - 6);
      end else begin
        wq(Q);
      end
      wq(Q/2);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    acked = ~sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
    logic s1, s2;
    steady = 1'b1;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      s1 = sda_bus; wq(Q);
      s2 = sda_bus;
      if (s1 !== s2) steady = 1'b0;
      b = {b[6:0], s1};
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sweep_val(input int n, input int k);
    return 8'((n * 37 + k * 11 + 3) & 8'hFF);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    bit st;
    logic [7:0] rb;
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h00 : 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R7 and R10: reset contents at their byte lanes
    chk("R7", 64'(cfg_bytes[7:0]), 64'h00);
    check_cfg("R7_R10");
    chk("R8", 64'(sda_pull), 64'h0);

    // R6: full read-back from byte 0, past the end gives FFh
    bus_start();
    send_byte(8'hD3, 1'b0, a); chk("R1 read addr ack", 64'(a), 64'h1);
    for (int k = 0; k <= NREG; k++) begin
      recv_byte(k < NREG, rb, st);
      chk("R6 read byte", 64'(rb), (k < NREG) ? 64'(model[k]) : 64'hFF);
      chk("R8 stable while SCL high", 64'(st), 64'h1);
    end
    bus_stop();

    // R2, R3, R4: short write with filler bytes that look like data
    bus_start();
    send_byte(8'hD2, 1'b0, a); chk("R1 write addr ack", 64'(a), 64'h1);
    send_byte(8'h5A, 1'b0, a); chk("R2 filler0 ack", 64'(a), 64'h1);
    send_byte(8'hA5, 1'b0, a); chk("R2 filler1 ack", 64'(a), 64'h1);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'h11 * (k + 1)), 1'b0, a);
      chk("R3 data ack", 64'(a), 64'h1);
      model[k] = 8'(8'h11 * (k + 1));
    end
    bus_stop();
    check_cfg("R2_R3_R4 short write");

    // R3, R4, R5: sweep write lengths 0..NREG+2
    for (int n = 0; n <= NREG + 2; n++) begin
      bus_start();
      send_byte(8'hD2, 1'b0, a); chk("R1 sweep addr", 64'(a), 64'h1);
      send_byte(8'h00, 1'b0, a); chk("R2 sweep filler", 64'(a), 64'h1);
      send_byte(8'hFF, 1'b0, a); chk("R2 sweep filler", 64'(a), 64'h1);
      for (int k = 0; k < n; k++) begin
        send_byte(sweep_val(n, k), 1'b0, a);
        chk((k < NREG) ? "R3 sweep ack" : "R5 overflow ack", 64'(a), 64'h1);
        if (k < NREG) model[k] = sweep_val(n, k);
      end
      bus_stop();
      check_cfg("R4_R5 sweep");
    end

    // R1: foreign addresses are refused, following bytes too
    bus_start();
    send_byte(8'hA4, 1'b0, a); chk("R1 foreign addr nack", 64'(a), 64'h0);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'h3C, 1'b0, a); chk("R1 ignored after nack", 64'(a), 64'h0);
    end
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1'b0, a); chk("R1 near addr nack", 64'(a), 64'h0);
    send_byte(8'h00, 1'b0, a); chk("R1 ignored after nack", 64'(a), 64'h0);
    send_byte(8'h00, 1'b0, a); chk("R1 ignored after nack", 64'(a), 64'h0);
    send_byte(8'h77, 1'b0, a); chk("R1 ignored after nack", 64'(a), 64'h0);
    bus_stop();
    check_cfg("R1 foreign leaves cfg");

    // R6: NACK ends read; repeated start reads from byte 0 again
    bus_start();
    send_byte(8'hD3, 1'b0, a); chk("R1 read addr ack", 64'(a), 64'h1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, rb, st);
      chk("R6 partial read", 64'(rb), 64'(model[k]));
    end
    bus_start();
    send_byte(8'hD3, 1'b0, a); chk("R1 reread addr ack", 64'(a), 64'h1);
    recv_byte(1'b0, rb, st);
    chk("R6 restart at byte 0", 64'(rb), 64'(model[0]));
    bus_stop();

    // R4: write that stops right after the filler bytes
    bus_start();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'h12, 1'b0, a);
    send_byte(8'h34, 1'b0, a); chk("R2 filler ack", 64'(a), 64'h1);
    bus_stop();
    check_cfg("R4 stop after filler");

    // R9: short pulses on both lines during every data bit
    bus_start();
    send_byte(8'hD2, 1'b1, a); chk("R9 addr ack with glitches", 64'(a), 64'h1);
    send_byte(8'h01, 1'b1, a);
    send_byte(8'h02, 1'b1, a);
    send_byte(8'hC3, 1'b1, a); chk("R9 data ack with glitches", 64'(a), 64'h1);
    send_byte(8'h5E, 1'b1, a); chk("R9 data ack with glitches", 64'(a), 64'h1);
    model[0] = 8'hC3; model[1] = 8'h5E;
    bus_stop();
    check_cfg("R9 glitch write");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule